// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two binary32 floating-point numbers. A new operation can be issued every clock. An operation is a pair of operands, a select that chooses sum or difference, and a valid strobe. The result comes back four clocks later with its own valid strobe and two flags. One flag reports that the exponent grew past the largest finite value. The other reports that the result fell below the smallest normal value. Both operands and the result use the usual layout: the sign in bit 31, the biased exponent (bias 127) in bits 30..23, and the fraction in bits 22..0. The hidden leading one is restored whenever the exponent field is nonzero.

The datapath has four register stages. The first stage orders the operands by magnitude and shifts the smaller significand right by the exponent gap. During that shift it keeps a guard bit, a round bit and a sticky bit. The second stage forms the sum or the difference of the significands. The third stage renormalizes, by one place to the right or by any number of places to the left, and corrects the exponent to match. The last stage rounds to nearest with ties to even, and renormalizes again if the rounding carries out of the significand. An exponent field of all ones marks infinities and NaNs, and those operands take a separate path. An exponent field of zero is read as zero whatever its fraction holds, so subnormal operands are flushed.

Top module: `fp32_addsub`

## Requirements
- R1: For finite normal operands, the result equals the exact sum, rounded once to a 24-bit significand, and carries the correct biased exponent.
- R2: The operation is an effective subtraction when sign(a) XOR sign(b) XOR op_sel is 1. op_sel = 0 means a+b and op_sel = 1 means a-b.
- R3: An operand whose exponent field is 0 counts as zero whatever its fraction bits hold.
- R4: A result that is exactly zero is 0x00000000, with ovf and unf both 0.
- R5: If either operand is a NaN (exponent all ones, fraction nonzero), the result is 0x7FC00000.
- R6: An infinite operand gives an infinity of that operand's effective sign. Infinities of opposite effective sign under effective subtraction give 0x7FC00000.
- R7: If the exponent after rounding reaches 255, the result is an infinity carrying the result sign, and ovf is 1.
- R8: A nonzero result whose normalized exponent is below 1 becomes a zero carrying the result sign, and unf is 1.
- R9: Rounding is to nearest, with ties going to an even significand. A carry out of the significand raises the exponent by one.
- R10: out_valid is high exactly four rising edges after in_valid is sampled high, and it is low at all other times.
- R11: While rst is high, out_valid, ovf and unf go to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op_sel are valid this cycle |
| op_sel | input | 1 | 0 = add, 1 = subtract b from a |
| opnd_a | input | 32 | First operand, binary32 |
| opnd_b | input | 32 | Second operand, binary32 |
| out_valid | output | 1 | result and flags are valid |
| result | output | 32 | Rounded binary32 result |
| ovf | output | 1 | Exponent overflow, result forced to infinity |
| unf | output | 1 | Exponent underflow, result forced to zero |

## Verification
The assertions assume the following about the inputs:
- rst is applied before the first operation.
- in_valid, op_sel and the operands carry known values on every sampled edge.
- No operation is in flight when reset is raised again.

The stimulus drives zeros on the operand inputs whenever in_valid is low. It resets once, at the start, and it runs idle cycles at the end to drain the pipeline. Under those conditions, the latency and the special-value properties can rely on the input seen four edges earlier.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic {FP_OP_ADD = 1'b0, FP_OP_SUB = 1'b1} fp_op_e;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align import fpadd_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = EXP_W + MAN_W + 1,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  fp_op_e           op_i,
  output logic             vld_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [EXT_W-1:0] big_o,
  output logic [EXT_W-1:0] small_o,
  output logic             sub_o,
  output logic             spec_o,
  output logic [W-1:0]     specval_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] EXT_LIM = EXP_W'(EXT_W);

  logic [EXP_W-1:0] ea, eb, e_big, e_small, diff;
  logic [MAN_W-1:0] fa, fb;
  logic             sa, sb, za, zb, nan_a, nan_b, inf_a, inf_b, a_big, eff_sub;
  logic [SIG_W-1:0] sig_a, sig_b, s_big, s_small;
  logic [EXT_W-1:0] ext, shifted, lost;
  logic             sticky;
  logic [W-1:0]     sval;

  always_comb begin
    sa = a_i[W-1];
    sb = b_i[W-1] ^ (op_i == FP_OP_SUB);
    ea = a_i[W-2:MAN_W];
    eb = b_i[W-2:MAN_W];
    fa = a_i[MAN_W-1:0];
    fb = b_i[MAN_W-1:0];
    za = (ea == '0);
    zb = (eb == '0);
    nan_a = (&ea) && (|fa);
    nan_b = (&eb) && (|fb);
    inf_a = (&ea) && !(|fa);
    inf_b = (&eb) && !(|fb);
    sig_a = za ? '0 : {1'b1, fa};
    sig_b = zb ? '0 : {1'b1, fb};
    eff_sub = sa ^ sb;
    a_big = {ea, sig_a} >= {eb, sig_b};
    e_big   = a_big ? ea : eb;
    e_small = a_big ? eb : ea;
    s_big   = a_big ? sig_a : sig_b;
    s_small = a_big ? sig_b : sig_a;
    diff = e_big - e_small;
    ext  = {s_small, 3'b000};
    if (diff >= EXT_LIM) begin
      shifted = '0;
      sticky  = |s_small;
      lost    = '0;
    end else begin
      shifted = ext >> diff;
      lost    = ext & ~({EXT_W{1'b1}} << diff);
      sticky  = |lost;
    end
    if (nan_a || nan_b || (inf_a && inf_b && eff_sub)) sval = QNAN;
    else if (inf_a) sval = {sa, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else            sval = {sb, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
    sign_o    <= a_big ? sa : sb;
    exp_o     <= e_big;
    big_o     <= {s_big, 3'b000};
    small_o   <= shifted | EXT_W'(sticky);
    sub_o     <= eff_sub;
    spec_o    <= nan_a | nan_b | inf_a | inf_b;
    specval_o <= sval;
  end
endmodule

// File: rtl/fpadd_sum.sv
module fpadd_sum #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = EXP_W + MAN_W + 1,
  localparam int EXT_W = MAN_W + 4,
  localparam int SUM_W = EXT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [EXT_W-1:0] big_i,
  input  logic [EXT_W-1:0] small_i,
  input  logic             sub_i,
  input  logic             spec_i,
  input  logic [W-1:0]     specval_i,
  output logic             vld_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SUM_W-1:0] sum_o,
  output logic             spec_o,
  output logic [W-1:0]     specval_o
);
  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
    sign_o    <= sign_i;
    exp_o     <= exp_i;
    sum_o     <= sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                       : ({1'b0, big_i} + {1'b0, small_i});
    spec_o    <= spec_i;
    specval_o <= specval_i;
  end

  // the larger magnitude is always the minuend, so a difference never borrows
  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
    (vld_i && sub_i && !spec_i) |=> !sum_o[SUM_W-1]) else $error("borrow"); // R2
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = EXP_W + MAN_W + 1,
  localparam int EXT_W = MAN_W + 4,
  localparam int SUM_W = EXT_W + 1,
  localparam int E_W   = EXP_W + 2,
  localparam int LZ_W  = $clog2(EXT_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic             spec_i,
  input  logic [W-1:0]     specval_i,
  output logic             vld_o,
  output logic             sign_o,
  output logic [E_W-1:0]   exp_o,
  output logic [EXT_W-1:0] man_o,
  output logic             zero_o,
  output logic             unf_o,
  output logic             spec_o,
  output logic [W-1:0]     specval_o
);
  logic [LZ_W-1:0]  lz;
  logic [EXT_W-1:0] man;
  logic [E_W-1:0]   en;

  always_comb begin
    lz = '0;
    for (int i = 0; i < EXT_W; i++)
      if (sum_i[i]) lz = LZ_W'(EXT_W - 1 - i);
    if (sum_i[SUM_W-1]) begin
      man = {sum_i[SUM_W-1:2], sum_i[1] | sum_i[0]};
      en  = E_W'(exp_i) + E_W'(1);
    end else begin
      man = sum_i[EXT_W-1:0] << lz;
      en  = E_W'(exp_i) - E_W'(lz);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
    sign_o    <= sign_i;
    exp_o     <= en;
    man_o     <= man;
    zero_o    <= (sum_i == '0);
    unf_o     <= (sum_i != '0) && (en[E_W-1] || en == '0);
    spec_o    <= spec_i;
    specval_o <= specval_i;
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = EXP_W + MAN_W + 1,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + 3,
  localparam int E_W   = EXP_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             sign_i,
  input  logic [E_W-1:0]   exp_i,
  input  logic [EXT_W-1:0] man_i,
  input  logic             zero_i,
  input  logic             unf_i,
  input  logic             spec_i,
  input  logic [W-1:0]     specval_i,
  output logic             vld_o,
  output logic [W-1:0]     res_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic             inc, big;
  logic [SIG_W:0]   r;
  logic [MAN_W-1:0] frac;
  logic [E_W-1:0]   er;

  always_comb begin
    inc  = man_i[2] & (man_i[1] | man_i[0] | man_i[3]);
    r    = {1'b0, man_i[EXT_W-1:3]} + (SIG_W+1)'(inc);
    frac = r[SIG_W] ? r[MAN_W:1] : r[MAN_W-1:0];
    er   = exp_i + E_W'(r[SIG_W]);
    big  = !er[E_W-1] && (er[EXP_W] || (&er[EXP_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      res_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (spec_i)      res_o <= specval_i;
      else if (zero_i) res_o <= '0;
      else if (unf_i) begin
        res_o <= {sign_i, {(W-1){1'b0}}};
        unf_o <= vld_i;
      end else if (big) begin
        res_o <= {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        ovf_o <= vld_i;
      end else res_o <= {sign_i, er[EXP_W-1:0], frac};
    end
  end

  AST_NORM_LEADING: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !spec_i && !zero_i) |-> man_i[EXT_W-1]) else $error("unnormalized"); // R1
  AST_OVF_INF: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (res_o[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}})) else $error("ovf"); // R7
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (res_o[W-2:0] == '0)) else $error("unf"); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o)) else $error("flags"); // R7
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub import fpadd_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = EXP_W + MAN_W + 1,
  localparam int EXT_W = MAN_W + 4,
  localparam int SUM_W = EXT_W + 1,
  localparam int E_W   = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         unf
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic v1, s1, sub1, sp1, v2, s2, sp2, v3, s3, z3, u3, sp3;
  logic [EXP_W-1:0] e1, e2;
  logic [EXT_W-1:0] big1, sml1, m3;
  logic [SUM_W-1:0] sum2;
  logic [E_W-1:0]   e3;
  logic [W-1:0]     sv1, sv2, sv3;
  fp_op_e           op;

  assign op = fp_op_e'(op_sel);

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk, .rst, .vld_i(in_valid), .a_i(opnd_a), .b_i(opnd_b), .op_i(op),
    .vld_o(v1), .sign_o(s1), .exp_o(e1), .big_o(big1), .small_o(sml1),
    .sub_o(sub1), .spec_o(sp1), .specval_o(sv1));

  fpadd_sum #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sum (
    .clk, .rst, .vld_i(v1), .sign_i(s1), .exp_i(e1), .big_i(big1), .small_i(sml1),
    .sub_i(sub1), .spec_i(sp1), .specval_i(sv1),
    .vld_o(v2), .sign_o(s2), .exp_o(e2), .sum_o(sum2), .spec_o(sp2), .specval_o(sv2));

  fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk, .rst, .vld_i(v2), .sign_i(s2), .exp_i(e2), .sum_i(sum2), .spec_i(sp2),
    .specval_i(sv2), .vld_o(v3), .sign_o(s3), .exp_o(e3), .man_o(m3), .zero_o(z3),
    .unf_o(u3), .spec_o(sp3), .specval_o(sv3));

  fpadd_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .clk, .rst, .vld_i(v3), .sign_i(s3), .exp_i(e3), .man_i(m3), .zero_i(z3),
    .unf_i(u3), .spec_i(sp3), .specval_i(sv3),
    .vld_o(out_valid), .res_o(result), .ovf_o(ovf), .unf_o(unf));

  AST_LATENCY_ON: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid) else $error("latency"); // R10
  AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##4 !out_valid) else $error("spurious"); // R10
  AST_NAN_IN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&opnd_a[W-2:MAN_W]) && (|opnd_a[MAN_W-1:0])) |-> ##4 (result == QNAN))
    else $error("nan"); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf && !unf)) else $error("reset"); // R11
endmodule

// File: tb/sim_fp32_addsub.sv
`timescale 1ns/1ps
module sim_fp32_addsub;
  localparam real HALF = 4.0;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, op_sel = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, result;
  logic out_valid, ovf, unf;
  int checks = 0, errors = 0, edge_n = 0;
  logic [31:0] q_res[$];
  logic q_ovf[$], q_unf[$];
  int q_due[$];
  string q_tag[$];

  always #(HALF) clk = ~clk;

  fp32_addsub u0 (.clk, .rst, .in_valid, .op_sel, .opnd_a, .opnd_b,
                  .out_valid, .result, .ovf, .unf);

  function automatic logic [33:0] ref_add(logic [31:0] a, logic [31:0] b, logic op);
    logic sa, sb, s, inc;
    logic [7:0] ea, eb;
    logic [319:0] ma, mb, mag, rem, half, q;
    int p, e, sh;
    sa = a[31]; sb = b[31] ^ op; ea = a[30:23]; eb = b[30:23];
    if ((&ea && |a[22:0]) || (&eb && |b[22:0])) return {2'b00, 32'h7FC00000};
    if (&ea && &eb && sa != sb) return {2'b00, 32'h7FC00000};
    if (&ea) return {2'b00, sa, 8'hFF, 23'd0};
    if (&eb) return {2'b00, sb, 8'hFF, 23'd0};
    ma = (ea == 0) ? '0 : (320'({1'b1, a[22:0]}) << (ea - 1));
    mb = (eb == 0) ? '0 : (320'({1'b1, b[22:0]}) << (eb - 1));
    if (sa == sb)    begin mag = ma + mb; s = sa; end
    else if (ma >= mb) begin mag = ma - mb; s = sa; end
    else             begin mag = mb - ma; s = sb; end
    if (mag == 0) return 34'd0;
    p = 0;
    for (int i = 0; i < 320; i++) if (mag[i]) p = i;
    e = p - 22;
    if (e < 1) return {2'b01, s, 31'd0};
    sh = p - 23;
    q = mag >> sh;
    if (sh > 0) begin
      rem  = mag & ~({320{1'b1}} << sh);
      half = 320'(1) << (sh - 1);
      inc  = (rem > half) || (rem == half && q[0]);
      q = q + 320'(inc);
    end
    if (q[24]) begin q = q >> 1; e = e + 1; end
    if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
    return {2'b00, s, 8'(e), q[22:0]};
  endfunction

  task automatic check_out();
    logic [33:0] x;
    checks++;
    if (q_due.size() > 0 && q_due[0] == edge_n) begin
      x = {q_ovf.pop_front(), q_unf.pop_front(), q_res.pop_front()};
      void'(q_due.pop_front());
      if (out_valid !== 1'b1 || result !== x[31:0] || ovf !== x[33] || unf !== x[32]) begin
        errors++;
        $display("FAIL %s: got v=%0b res=%h ovf=%0b unf=%0b, expected v=1 res=%h ovf=%0b unf=%0b",
                 q_tag[0], out_valid, result, ovf, unf, x[31:0], x[33], x[32]);
      end
      void'(q_tag.pop_front());
    end else if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: got out_valid=%0b, expected 0", out_valid);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] x, input logic [31:0] y,
                       input logic o, input string tag);
    logic [33:0] r;
    in_valid = v; opnd_a = v ? x : '0; opnd_b = v ? y : '0; op_sel = v ? o : 1'b0;
    @(posedge clk);
    edge_n++;
    if (v) begin
      r = ref_add(x, y, o);
      q_res.push_back(r[31:0]); q_ovf.push_back(r[33]); q_unf.push_back(r[32]);
      q_due.push_back(edge_n + 3); q_tag.push_back(tag);
    end
    #2;
    check_out();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL R10: watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || ovf !== 1'b0 || unf !== 1'b0) begin
      errors++;
      $display("FAIL R11: got v=%0b ovf=%0b unf=%0b, expected 0 0 0", out_valid, ovf, unf);
    end
    rst = 1'b0;
    drive(1, 32'h3F800000, 32'h3F800000, 0, "R1");  // 1+1 = 2
    drive(1, 32'h3FC00000, 32'h40100000, 0, "R1");  // 1.5+2.25
    drive(1, 32'h40A00000, 32'h40400000, 1, "R2");  // 5-3
    drive(1, 32'h40A00000, 32'hC0400000, 0, "R2");  // 5+(-3)
    drive(1, 32'hC0A00000, 32'hC0400000, 1, "R2");  // -5-(-3)
    drive(1, 32'h40400000, 32'h40A00000, 1, "R2");  // 3-5 negative
    drive(0, 0, 0, 0, "");
    drive(1, 32'h00000001, 32'h3F800000, 0, "R3");  // subnormal reads as zero
    drive(1, 32'h007FFFFF, 32'h80400000, 0, "R3");  // both flushed
    drive(1, 32'h3F800000, 32'h3F800000, 1, "R4");  // 1-1 = +0
    drive(1, 32'hC0000000, 32'h40000000, 0, "R4");
    drive(1, 32'h80000000, 32'h80000000, 0, "R4");
    drive(1, 32'h7FC00001, 32'h3F800000, 0, "R5");
    drive(1, 32'h3F800000, 32'hFF800001, 1, "R5");
    drive(1, 32'h7F800000, 32'h3F800000, 0, "R6");
    drive(1, 32'h3F800000, 32'h7F800000, 1, "R6");  // 1-inf = -inf
    drive(1, 32'h7F800000, 32'h7F800000, 1, "R6");  // inf-inf = NaN
    drive(1, 32'h7F800000, 32'hFF800000, 0, "R6");
    drive(1, 32'hFF800000, 32'hFF800000, 0, "R6");
    drive(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, "R7");
    drive(1, 32'h7F7FFFFF, 32'h73000000, 0, "R7");  // tie rounds past max
    drive(1, 32'hFF7FFFFF, 32'h7F7FFFFF, 1, "R7");
    drive(1, 32'h00800001, 32'h00800000, 1, "R8");  // +0, unf
    drive(1, 32'h00800000, 32'h00800001, 1, "R8");  // -0, unf
    drive(1, 32'h3F800000, 32'h33800000, 0, "R9");  // tie, stays even
    drive(1, 32'h3F800001, 32'h33800000, 0, "R9");  // tie, rounds up to even
    drive(1, 32'h3FFFFFFF, 32'h34000000, 0, "R9");  // carry out renormalizes
    drive(1, 32'h3F800000, 32'h33800001, 0, "R9");  // above half
    for (int i = 0; i < 300; i++) begin
      ra = $urandom;
      rb = (i % 2 == 0) ? $urandom
                        : {1'($urandom), 8'(ra[30:23] + 8'($urandom_range(0, 2)) - 8'd1), 23'($urandom)};
      drive(1'(i % 7 != 3), ra, rb, 1'($urandom), "R1");
    end
    repeat (6) drive(0, 0, 0, 0, "");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule